// File: doc/BRIEF.md
# Two-Stage Training-Based Carrier Frequency Offset Estimator

This block measures the carrier frequency offset of a receiver from a known training pattern that arrives before the payload. The pattern is two training symbols of N samples each. The first symbol is made of two identical halves. The second symbol repeats the first. A frequency offset turns into a phase rotation that grows linearly with the sample index. The block measures that rotation twice. The short baseline of half a symbol gives a coarse slope that is unambiguous over a wide range. The long baseline of a full symbol gives a fine slope that is accurate but wraps every 2π/N per sample. The coarse slope selects which wrap of the fine slope is correct.

The block keeps one symbol of history in a circular sample buffer. It accumulates both conjugate-product correlations while the samples stream in. It then resolves the angle of each sum with one shared iterative vectoring CORDIC. The result is a signed phase increment per sample. A matched forward and reverse rotation pair is also given, for the later IQ-imbalance step, which rotates the second training symbol both ways by the estimated amount. A done level marks the point where the outputs are valid. A new training-start strobe aborts any estimate in progress.

Top module: `cfo_estimator`

## Requirements
- R1: After reset, done is 0 and phase_inc, rot_fwd and rot_rev are all 0.
- R2: A training start is taken only in a cycle where train_start and in_valid are both 1. The sample in that cycle is training sample 0. Later samples are counted only in cycles where in_valid is 1. Samples and train_start while in_valid is 0 are ignored, and so are samples that arrive when no estimate is running.
- R3: The coarse correlation sums conj(r[n])·r[n+N/2] for n = 0..N/2-1. The fine correlation sums conj(r[n])·r[n+N] for n = 0..N-1. Each angle is a signed 16-bit word in which 32768 stands for π radians.
- R4: phase_inc is an 18-bit two's-complement value in units of π/(32768·N) radians per sample. It equals F + m·65536, where F is the fine angle and C is the coarse angle. With d = 2C − F, m is +1 when d > 32768, −1 when d < −32768, and 0 otherwise.
- R5: rot_fwd equals phase_inc, and rot_rev is its two's-complement negation.
- R6: done rises exactly 35 clock edges after the edge that accepts training sample 2N−1. It then stays 1, with phase_inc, rot_fwd and rot_rev unchanged, until the next accepted training start.
- R7: An accepted training start during collection, during angle resolution, or while done is 1 clears done at that edge. It discards the partial correlations and restarts the estimate with its own sample as sample 0.
- R8: For noise-free, constant-offset training, phase_inc is within 6 units of the value obtained by applying R4 to the exact correlation angles, rounded to the 16-bit scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is present on in_re/in_im |
| in_re | input | W | Signed in-phase sample |
| in_im | input | W | Signed quadrature sample |
| train_start | input | 1 | Marks the first sample of the training pattern |
| phase_inc | output | 18 | Signed per-sample phase increment estimate |
| rot_fwd | output | 18 | Forward rotation step for IQ estimation |
| rot_rev | output | 18 | Reverse rotation step for IQ estimation |
| done | output | 1 | Estimate complete; outputs valid |

## Verification
On every cycle, the assertions check the following. An accepted start drops done and returns the block to collection. The outputs hold still while done stays high. The combined increment never lies more than half a wrap step from twice the coarse angle. Done can only rise from the combine step. The angle accuracy, the choice of wrap for offsets beyond the fine range, the exact latency of 35 edges, pausing on invalid cycles, and aborts in each phase can only be shown by the bench's scenarios. There, a behavioural model correlates the driven samples in floating point and tracks the expected done level cycle by cycle.

// File: rtl/cfo_estimator.sv
module cfo_estimator #(
  parameter int N = 2048,
  parameter int W = 12,
  localparam int IW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  input  logic                 train_start,
  output logic signed [IW-1:0] phase_inc,
  output logic signed [IW-1:0] rot_fwd,
  output logic signed [IW-1:0] rot_rev,
  output logic                 done
);
  localparam int PW   = 16;
  localparam int LN   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int PRW  = 2 * W + 1;
  localparam int AW   = PRW + LN;
  localparam int CW   = AW + 2;
  localparam logic [LN:0]   K_LAST = (LN+1)'(2 * N - 1);
  localparam logic [LN-1:0] H_FLIP = LN'(HALF);

  typedef enum logic [2:0] {S_IDLE, S_COLL, S_LOAD, S_ITER, S_COMB} st_t;

  function automatic logic signed [PW-1:0] atan_step(input logic [3:0] i);
    case (i)
      4'd0:  return 16'sd8192;
      4'd1:  return 16'sd4836;
      4'd2:  return 16'sd2555;
      4'd3:  return 16'sd1297;
      4'd4:  return 16'sd651;
      4'd5:  return 16'sd326;
      4'd6:  return 16'sd163;
      4'd7:  return 16'sd81;
      4'd8:  return 16'sd41;
      4'd9:  return 16'sd20;
      4'd10: return 16'sd10;
      4'd11: return 16'sd5;
      4'd12: return 16'sd3;
      4'd13: return 16'sd1;
      4'd14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  st_t st;
  logic [LN:0] k;
  logic sel;
  logic [3:0] it;
  logic signed [W-1:0] buf_re [N];
  logic signed [W-1:0] buf_im [N];
  logic signed [AW-1:0] c_re, c_im, f_re, f_im;
  logic signed [CW-1:0] x, y, xn, yn;
  logic signed [PW-1:0] z, zn, ang_c, ang_f;

  wire go   = train_start && in_valid;
  wire take = in_valid && !go && (st == S_COLL);
  wire we   = go || take;
  wire [LN-1:0] wp = k[LN-1:0];
  wire [LN-1:0] wa = go ? '0 : wp;

  always_ff @(posedge clk)
    if (we) begin
      buf_re[wa] <= in_re;
      buf_im[wa] <= in_im;
    end

  logic signed [W-1:0] d_re, d_im;
  logic signed [PRW-1:0] er, ei, xr, xi, pr, pi;
  always_comb begin
    d_re = k[LN] ? buf_re[wp] : buf_re[wp ^ H_FLIP];
    d_im = k[LN] ? buf_im[wp] : buf_im[wp ^ H_FLIP];
    er = {{(W+1){d_re[W-1]}}, d_re};
    ei = {{(W+1){d_im[W-1]}}, d_im};
    xr = {{(W+1){in_re[W-1]}}, in_re};
    xi = {{(W+1){in_im[W-1]}}, in_im};
    pr = er * xr + ei * xi;
    pi = er * xi - ei * xr;
  end

  wire signed [AW-1:0] pr_x = {{LN{pr[PRW-1]}}, pr};
  wire signed [AW-1:0] pi_x = {{LN{pi[PRW-1]}}, pi};
  wire coarse_on = !k[LN] && k[LN-1];

  wire signed [AW-1:0] src_re = sel ? f_re : c_re;
  wire signed [AW-1:0] src_im = sel ? f_im : c_im;
  wire signed [CW-1:0] sx = {{2{src_re[AW-1]}}, src_re};
  wire signed [CW-1:0] sy = {{2{src_im[AW-1]}}, src_im};

  always_comb begin
    if (!y[CW-1]) begin
      xn = x + (y >>> it);
      yn = y - (x >>> it);
      zn = z + atan_step(it);
    end else begin
      xn = x - (y >>> it);
      yn = y + (x >>> it);
      zn = z - atan_step(it);
    end
  end

  logic signed [IW-1:0] c2, pf18, inc_n;
  logic signed [IW:0] diff, gap;
  always_comb begin
    c2   = {ang_c[PW-1], ang_c, 1'b0};
    pf18 = {{2{ang_f[PW-1]}}, ang_f};
    diff = {c2[IW-1], c2} - {pf18[IW-1], pf18};
    if (diff > 19'sd32768)       inc_n = pf18 + 18'sd65536;
    else if (diff < -19'sd32768) inc_n = pf18 - 18'sd65536;
    else                         inc_n = pf18;
    gap = {c2[IW-1], c2} - {phase_inc[IW-1], phase_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; sel <= 1'b0; it <= '0;
      c_re <= '0; c_im <= '0; f_re <= '0; f_im <= '0;
      x <= '0; y <= '0; z <= '0; ang_c <= '0; ang_f <= '0;
      phase_inc <= '0; done <= 1'b0;
    end else if (go) begin
      st <= S_COLL; k <= (LN+1)'(1); done <= 1'b0;
      c_re <= '0; c_im <= '0; f_re <= '0; f_im <= '0;
    end else begin
      case (st)
        S_COLL: if (in_valid) begin
          k <= k + 1'b1;
          if (coarse_on) begin c_re <= c_re + pr_x; c_im <= c_im + pi_x; end
          if (k[LN])     begin f_re <= f_re + pr_x; f_im <= f_im + pi_x; end
          if (k == K_LAST) begin st <= S_LOAD; sel <= 1'b0; end
        end
        S_LOAD: begin
          it <= '0; st <= S_ITER;
          if (!sy[CW-1]) begin x <= sy;  y <= -sx; z <= 16'sd16384;  end
          else           begin x <= -sy; y <= sx;  z <= -16'sd16384; end
        end
        S_ITER: begin
          x <= xn; y <= yn; z <= zn; it <= it + 1'b1;
          if (it == 4'd15) begin
            if (!sel) begin ang_c <= zn; sel <= 1'b1; st <= S_LOAD; end
            else      begin ang_f <= zn; st <= S_COMB; end
          end
        end
        S_COMB: begin phase_inc <= inc_n; done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rot_fwd = phase_inc;
  assign rot_rev = -phase_inc;

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!done && st == S_COLL));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && $stable(phase_inc)));
  p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == S_COMB));
  p_nearest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gap <= 19'sd32768 && gap >= -19'sd32768));
  p_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && k == K_LAST) |=> (st == S_LOAD && !done));
endmodule

// File: tb/sim_cfo_estimator.sv
module sim_cfo_estimator;
  localparam int N = 64;
  localparam int W = 12;
  localparam int TOL = 6;
  localparam real PI = 3.14159265358979;

  logic clk = 0, rst_n = 0, in_valid = 0, train_start = 0;
  logic signed [W-1:0] in_re = 0, in_im = 0;
  logic signed [17:0] phase_inc, rot_fwd, rot_rev;
  logic done;

  cfo_estimator #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .train_start(train_start), .phase_inc(phase_inc), .rot_fwd(rot_fwd),
    .rot_rev(rot_rev), .done(done));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int to_word(input real a);
    int v = int'(a * 32768.0 / PI);
    if (v >= 32768) v -= 65536;
    if (v < -32768) v += 65536;
    return v;
  endfunction

  int qre[$], qim[$];
  bit coll = 0, exp_done = 0, held_v = 0;
  int cd = 0, pend = 0, exp_inc = 0;
  longint held = 0;

  function automatic int model_inc();
    real cr = 0, ci = 0, fr = 0, fi = 0;
    int pc, pf, d;
    for (int n = 0; n < N/2; n++) begin
      cr += real'(qre[n]*qre[n+N/2] + qim[n]*qim[n+N/2]);
      ci += real'(qre[n]*qim[n+N/2] - qim[n]*qre[n+N/2]);
    end
    for (int n = 0; n < N; n++) begin
      fr += real'(qre[n]*qre[n+N] + qim[n]*qim[n+N]);
      fi += real'(qre[n]*qim[n+N] - qim[n]*qre[n+N]);
    end
    pc = to_word($atan2(ci, cr));
    pf = to_word($atan2(fi, fr));
    d = 2*pc - pf;
    return pf + ((d > 32768) ? 65536 : (d < -32768) ? -65536 : 0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      coll = 0; exp_done = 0; cd = 0;
    end else if (train_start && in_valid) begin
      qre.delete(); qim.delete();
      qre.push_back(int'(in_re)); qim.push_back(int'(in_im));
      coll = 1; cd = 0; exp_done = 0;
    end else if (coll && in_valid) begin
      qre.push_back(int'(in_re)); qim.push_back(int'(in_im));
      if (qre.size() == 2*N) begin pend = model_inc(); coll = 0; cd = 35; end
    end else if (cd > 0) begin
      cd--;
      if (cd == 0) begin exp_done = 1; exp_inc = pend; end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(done == 1'b0, "R1 done in reset", done, 0);
      chk(phase_inc == 0 && rot_fwd == 0 && rot_rev == 0, "R1 outputs in reset", phase_inc, 0);
    end else begin
      chk(done == exp_done, "R2 R6 R7 done level", done, exp_done);
      if (exp_done && done) begin
        chk((phase_inc - exp_inc <= TOL) && (exp_inc - phase_inc <= TOL),
            "R3 R4 R8 phase_inc", phase_inc, exp_inc);
        chk(rot_rev == -rot_fwd && rot_fwd == phase_inc, "R5 rotation pair", rot_rev, -rot_fwd);
        if (held_v) chk(phase_inc == held, "R6 held output", phase_inc, held);
        else begin held = phase_inc; held_v = 1; end
      end else held_v = 0;
    end
  end

  task automatic put(input bit v, input bit s, input int re, input int im);
    @(negedge clk);
    in_valid = v; train_start = s;
    in_re = W'(re); in_im = W'(im);
  endtask

  task automatic train(input real wn, input int gap, input int count);
    real w = wn * PI / N;
    for (int n = 0; n < count; n++) begin
      int b = n % (N/2);
      real ph = 0.37 * b * b + 0.5 * b + w * n;
      if (gap > 0 && n % gap == gap - 1) put(0, 1, 777, -555);
      put(1, n == 0, int'(1500.0 * $cos(ph)), int'(1500.0 * $sin(ph)));
    end
    put(0, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(i % 2, (i % 3) == 0 ? 1'b0 : 1'b0, 300 + i, -200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(6);                        // R2 samples with no start ignored
    train(0.3, 0, 2*N);  idle(45);  // m = 0
    put(0, 1, 5, 5);                // R2 start without valid ignored
    idle(4);
    train(1.5, 0, 2*N);  idle(45);  // R4 m = +1
    train(-1.8, 0, 2*N); idle(45);  // R4 m = -1
    train(-0.4, 5, 2*N); idle(45);  // R2 gaps in valid
    train(0.9, 0, 40);              // R7 abort during collection
    train(0.7, 0, 2*N);  idle(10);  // R7 abort during angle resolution
    train(-1.2, 0, 2*N); idle(50);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule